// File: doc/BRIEF.md
# Byte-Serial 8-Bit Processor Core

This block is a small multi-cycle processor. It has four 8-bit general registers, a 16-bit program counter, and zero and carry flags. It reads its program one byte at a time over a synchronous read-only memory port. The core drives an address and a read strobe, and the memory returns the addressed byte on the next clock edge. Instructions are either one byte or three bytes long. The core runs move, add, subtract, compare, absolute jump, jump-if-zero, jump-if-not-zero and halt.

The core stops in one of two ways. A halt instruction stops it. An opcode that is not in the instruction map also stops it, and in that case it raises an error output as well. Once stopped, the core issues no further memory reads and holds its state until reset. The register contents and the flags are brought out on ports so that the surrounding logic can see the machine state.

A three-byte instruction takes four cycles: three fetch cycles and one execute cycle. Halt and an illegal opcode each take two cycles before the core is stopped.

Top module: `cpu8_core`

## Requirements
- R1: After reset the program counter, all four registers and both flags are zero, the halted and error outputs are low, and the first read is issued at address 0.
- R2: Bytes are read at consecutive addresses, one per read cycle, and each byte is sampled one cycle after its address was driven. Opcode 0xFF is one byte long. Every other legal opcode is three bytes long: opcode, first operand, second operand.
- R3: Opcode 0x01 (first operand = destination index, second = 8-bit immediate) and opcode 0x08 (second operand = source index) write the moved value to the destination. They set zero when that value is 0 and leave carry unchanged.
- R4: Opcode 0x02 (destination index, source index) writes the 8-bit wrapped sum to the destination, sets zero from the result, and sets carry to the unsigned carry-out.
- R5: Opcode 0x03 (destination index, source index) writes the 8-bit wrapped difference destination minus source, sets zero from the result, and sets carry when an unsigned borrow occurs.
- R6: Opcode 0x07 (left index, immediate) and opcode 0x09 (left index, right index) compute left minus right. They set zero when the difference is 0 and carry on an unsigned borrow, and they change no register.
- R7: Opcode 0x04 jumps to the 16-bit absolute address formed by the two operand bytes, low byte first.
- R8: Opcode 0x05 jumps only when zero is set, and opcode 0x06 jumps only when zero is clear. When the jump is not taken, the next fetch is the byte after the instruction.
- R9: Register indices 0 to 3 select registers A to D. Reading an index above 3 yields 0, and writing to an index above 3 changes no register.
- R10: Opcode 0xFF sets halted. While halted the core issues no reads, and its registers and flags hold their values.
- R11: An opcode outside the map sets both halted and error, and no operand bytes are read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 16 | Read address into program memory |
| mem_rd_o | output | 1 | High in each cycle where a byte read is issued |
| mem_rdata_i | input | 8 | Byte returned one cycle after its address |
| regs_o | output | 32 | Registers D, C, B, A from the top byte down (A in bits 7:0) |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow flag |
| halted_o | output | 1 | Core has stopped |
| error_o | output | 1 | Core stopped on an illegal opcode |

## Verification
The bench checks every read address against a scoreboard. This catches a core that samples a byte one cycle too early, decodes halt as a three-byte instruction, assembles a jump target with its bytes swapped, or takes a conditional jump on the wrong sense of the zero flag; any of these shows up as an out-of-place address. Wrapping addition with carry-out and subtraction with borrow are set up so that an inverted borrow or a lost carry leaves a wrong final flag. A compare is placed in front of a conditional jump, so a compare that wrote its register or computed zero wrongly goes down a path the scoreboard rejects. Out-of-range register indices are used both as a move destination and as a move source, and an illegal opcode is run to confirm that the core stops with error set and reads no operand bytes.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int BYTE_W = 8;
    localparam int PC_W   = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OPC_MOVI = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_ADD  = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_SUB  = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_JMP  = 8'h04;
    localparam logic [BYTE_W-1:0] OPC_JZ   = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_JNZ  = 8'h06;
    localparam logic [BYTE_W-1:0] OPC_CMPI = 8'h07;
    localparam logic [BYTE_W-1:0] OPC_MOVR = 8'h08;
    localparam logic [BYTE_W-1:0] OPC_CMPR = 8'h09;
    localparam logic [BYTE_W-1:0] OPC_HLT  = 8'hFF;

    typedef enum logic [2:0] {
        S_OPCODE,
        S_ARG1,
        S_ARG2,
        S_EXEC,
        S_STOP
    } fsm_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB
    } alu_op_e;

    typedef struct packed {
        fsm_e              fsm;
        logic [PC_W-1:0]   pc;
        logic [BYTE_W-1:0] opcode;
        logic [BYTE_W-1:0] arg1;
        logic              zero;
        logic              carry;
        logic              error;
    } core_state_t;

    function automatic logic is_three_byte(input logic [BYTE_W-1:0] opc);
        return (opc == OPC_MOVI) || (opc == OPC_ADD)  || (opc == OPC_SUB)  ||
               (opc == OPC_JMP)  || (opc == OPC_JZ)   || (opc == OPC_JNZ)  ||
               (opc == OPC_CMPI) || (opc == OPC_MOVR) || (opc == OPC_CMPR);
    endfunction

endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    output logic [BYTE_W-1:0] result_o,
    output logic              carry_o,
    output logic              zero_o
);

    logic [BYTE_W:0] wide_d;

    always_comb begin
        wide_d = '0;
        unique case (op_i)
            ALU_ADD: wide_d = {1'b0, a_i} + {1'b0, b_i};
            ALU_SUB: wide_d = {1'b0, a_i} - {1'b0, b_i};
            default: wide_d = {1'b0, b_i};
        endcase
        result_o = wide_d[BYTE_W-1:0];
        carry_o  = wide_d[BYTE_W];
        zero_o   = (wide_d[BYTE_W-1:0] == '0);
    end

    // R4 / R5: carry agrees with an unsigned comparison of the operands
    always_comb begin
        if (op_i == ALU_SUB) begin
            a_r5_borrow_matches_compare: assert (carry_o == (a_i < b_i));
        end
        if (op_i == ALU_ADD) begin
            a_r4_carry_matches_wrap: assert (carry_o == (result_o < a_i));
        end
    end

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
    import cpu8_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int FLAT_W  = NUM_REGS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rd_idx_a_i,
    input  logic [BYTE_W-1:0] rd_idx_b_i,
    output logic [BYTE_W-1:0] rd_val_a_o,
    output logic [BYTE_W-1:0] rd_val_b_o,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_idx_i,
    input  logic [BYTE_W-1:0] wr_val_i,
    output logic [FLAT_W-1:0] regs_flat_o
);

    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic [BYTE_W-1:0] regs_d [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en_i && (wr_idx_i == BYTE_W'(g))) begin
                regs_d[g] = wr_val_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end

        assign regs_flat_o[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    // Out-of-range indices read as zero
    always_comb begin
        rd_val_a_o = '0;
        rd_val_b_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx_a_i == BYTE_W'(i)) rd_val_a_o = regs_q[i];
            if (rd_idx_b_i == BYTE_W'(i)) rd_val_b_o = regs_q[i];
        end
    end

    // R9: a write aimed past the last register leaves every register alone
    a_r9_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_idx_i >= BYTE_W'(NUM_REGS))) |=> $stable(regs_flat_o));

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int FLAT_W  = NUM_REGS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   mem_addr_o,
    output logic              mem_rd_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    output logic [FLAT_W-1:0] regs_o,
    output logic              zero_o,
    output logic              carry_o,
    output logic              halted_o,
    output logic              error_o
);

    core_state_t cur_q, nxt_d;

    logic [BYTE_W-1:0] rd_val_a, rd_val_b;
    logic              wr_en_d;
    logic [BYTE_W-1:0] alu_b_d;
    alu_op_e           alu_op_d;
    logic [BYTE_W-1:0] alu_res;
    logic              alu_carry, alu_zero;
    logic [PC_W-1:0]   pc_inc;

    assign pc_inc = cur_q.pc + PC_W'(1);

    cpu8_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx_a_i  (cur_q.arg1),
        .rd_idx_b_i  (mem_rdata_i),
        .rd_val_a_o  (rd_val_a),
        .rd_val_b_o  (rd_val_b),
        .wr_en_i     (wr_en_d),
        .wr_idx_i    (cur_q.arg1),
        .wr_val_i    (alu_res),
        .regs_flat_o (regs_o)
    );

    cpu8_alu u_alu (
        .op_i     (alu_op_d),
        .a_i      (rd_val_a),
        .b_i      (alu_b_d),
        .result_o (alu_res),
        .carry_o  (alu_carry),
        .zero_o   (alu_zero)
    );

    always_comb begin
        nxt_d      = cur_q;
        mem_rd_o   = 1'b0;
        mem_addr_o = cur_q.pc;
        wr_en_d    = 1'b0;
        alu_op_d   = ALU_PASS;
        alu_b_d    = mem_rdata_i;

        unique case (cur_q.fsm)
            S_OPCODE: begin
                mem_rd_o  = 1'b1;
                nxt_d.pc  = pc_inc;
                nxt_d.fsm = S_ARG1;
            end

            S_ARG1: begin
                nxt_d.opcode = mem_rdata_i;
                if (mem_rdata_i == OPC_HLT) begin
                    nxt_d.fsm = S_STOP;
                end else if (!is_three_byte(mem_rdata_i)) begin
                    nxt_d.fsm   = S_STOP;
                    nxt_d.error = 1'b1;
                end else begin
                    mem_rd_o  = 1'b1;
                    nxt_d.pc  = pc_inc;
                    nxt_d.fsm = S_ARG2;
                end
            end

            S_ARG2: begin
                nxt_d.arg1 = mem_rdata_i;
                mem_rd_o   = 1'b1;
                nxt_d.pc   = pc_inc;
                nxt_d.fsm  = S_EXEC;
            end

            S_EXEC: begin
                nxt_d.fsm = S_OPCODE;
                unique case (cur_q.opcode)
                    OPC_MOVI, OPC_MOVR: begin
                        alu_op_d   = ALU_PASS;
                        alu_b_d    = (cur_q.opcode == OPC_MOVR) ? rd_val_b : mem_rdata_i;
                        wr_en_d    = 1'b1;
                        nxt_d.zero = alu_zero;
                    end
                    OPC_ADD, OPC_SUB: begin
                        alu_op_d    = (cur_q.opcode == OPC_ADD) ? ALU_ADD : ALU_SUB;
                        alu_b_d     = rd_val_b;
                        wr_en_d     = 1'b1;
                        nxt_d.zero  = alu_zero;
                        nxt_d.carry = alu_carry;
                    end
                    OPC_CMPI, OPC_CMPR: begin
                        alu_op_d    = ALU_SUB;
                        alu_b_d     = (cur_q.opcode == OPC_CMPR) ? rd_val_b : mem_rdata_i;
                        nxt_d.zero  = alu_zero;
                        nxt_d.carry = alu_carry;
                    end
                    OPC_JMP: begin
                        nxt_d.pc = {mem_rdata_i, cur_q.arg1};
                    end
                    OPC_JZ: begin
                        if (cur_q.zero) nxt_d.pc = {mem_rdata_i, cur_q.arg1};
                    end
                    OPC_JNZ: begin
                        if (!cur_q.zero) nxt_d.pc = {mem_rdata_i, cur_q.arg1};
                    end
                    default: begin
                        nxt_d.fsm   = S_STOP;
                        nxt_d.error = 1'b1;
                    end
                endcase
            end

            default: begin
                nxt_d.fsm = S_STOP;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{fsm: S_OPCODE, pc: '0, opcode: '0, arg1: '0,
                       zero: 1'b0, carry: 1'b0, error: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign zero_o   = cur_q.zero;
    assign carry_o  = cur_q.carry;
    assign halted_o = (cur_q.fsm == S_STOP);
    assign error_o  = cur_q.error;

    // R10: no reads while stopped, and the stop is permanent with frozen state
    a_r10_no_fetch_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !mem_rd_o);
    a_r10_halt_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (halted_o && $stable(regs_o) && $stable(zero_o) && $stable(carry_o)));

    // R11: an error always comes with a stop
    a_r11_error_implies_halt: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> halted_o);

    // R2: second operand address follows the first
    a_r2_sequential_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.fsm == S_ARG2) |-> (mem_rd_o && (mem_addr_o == $past(mem_addr_o) + PC_W'(1))));

    // R6: compare never touches the register file
    a_r6_cmp_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.fsm == S_EXEC) && ((cur_q.opcode == OPC_CMPI) || (cur_q.opcode == OPC_CMPR)))
        |=> $stable(regs_o));

    // R7: next opcode read lands on the assembled target, low byte first
    a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.fsm == S_EXEC) && (cur_q.opcode == OPC_JMP))
        |=> (mem_addr_o == {$past(mem_rdata_i), $past(cur_q.arg1)}));

    // R8: an untaken conditional jump falls through to the next byte
    a_r8_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.fsm == S_EXEC) &&
         (((cur_q.opcode == OPC_JZ) && !cur_q.zero) || ((cur_q.opcode == OPC_JNZ) && cur_q.zero)))
        |=> (mem_addr_o == $past(cur_q.pc)));

endmodule

// File: tb/cpu8_core_test.sv
module cpu8_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic [31:0] regs;
    logic        zero, carry, halted, error;

    logic [7:0]  mem [1024];
    logic [15:0] exp_q [$];
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #5 clk = ~clk;

    cpu8_core uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr_o  (mem_addr),
        .mem_rd_o    (mem_rd),
        .mem_rdata_i (mem_rdata),
        .regs_o      (regs),
        .zero_o      (zero),
        .carry_o     (carry),
        .halted_o    (halted),
        .error_o     (error)
    );

    // Program memory: byte appears one edge after its address
    always @(posedge clk) mem_rdata <= mem[mem_addr[9:0]];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every issued read must match the next expected address (R2, R10)
    always @(negedge clk) begin
        if (rst_n && mem_rd && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected read", {16'h0, mem_addr}, 32'hFFFF_FFFF);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(mem_addr == e, "R2 read address", {16'h0, mem_addr}, {16'h0, e});
            end
        end
    end

    // Driver helpers
    task automatic put3(input int a, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        mem[a] = b0; mem[a+1] = b1; mem[a+2] = b2;
    endtask

    task automatic push_reads(input int start, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(16'(start + i));
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        exp_q.delete();
    endtask

    task automatic hold_reset();
        @(posedge clk); #1 rst_n = 1'b0;
    endtask

    task automatic run(input string req);
        int cyc;
        @(posedge clk); #1 rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (10) @(negedge clk);
        chk(halted == 1'b1, req, {31'h0, halted}, 32'h1);
        chk(exp_q.size() == 0, "R2 reads left over", exp_q.size(), 32'h0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // ---- Program 1: moves, add with carry, out-of-range indices (R3, R4, R9)
        clear_mem();
        put3(0,  8'h01, 8'h00, 8'd200);   // A = 200
        put3(3,  8'h01, 8'h01, 8'd100);   // B = 100
        put3(6,  8'h02, 8'h00, 8'h01);    // A = A + B -> 44, carry
        put3(9,  8'h08, 8'h02, 8'h00);    // C = A
        put3(12, 8'h01, 8'h07, 8'd55);    // index 7: ignored write
        put3(15, 8'h08, 8'h03, 8'h05);    // D = reg[5] = 0, zero set
        mem[18] = 8'hFF;
        push_reads(0, 19);
        hold_reset();
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(regs == 32'h0, "R1 regs", regs, 32'h0);
        chk({zero, carry, halted, error} == 4'b0, "R1 flags", {28'h0, zero, carry, halted, error}, 32'h0);
        chk(mem_addr == 16'h0 && mem_rd, "R1 first read", {15'h0, mem_rd, mem_addr}, 32'h0001_0000);
        run("R10 halt p1");
        chk(regs == {8'd0, 8'd44, 8'd100, 8'd44}, "R4 R9 regs p1", regs, {8'd0, 8'd44, 8'd100, 8'd44});
        chk(zero == 1'b1, "R3 zero from moved 0 (R9 read)", {31'h0, zero}, 32'h1);
        chk(carry == 1'b1, "R4 carry kept by R3 moves", {31'h0, carry}, 32'h1);
        chk(error == 1'b0, "R10 no error on halt", {31'h0, error}, 32'h0);

        // ---- Program 2: subtract with borrow, compares (R5, R6, R8)
        hold_reset();
        clear_mem();
        put3(0,  8'h01, 8'h00, 8'd5);     // A = 5
        put3(3,  8'h01, 8'h01, 8'd9);     // B = 9
        put3(6,  8'h03, 8'h00, 8'h01);    // A = 5 - 9 = 252, borrow
        put3(9,  8'h07, 8'h01, 8'd9);     // cmp B, 9 -> zero
        put3(12, 8'h05, 8'h30, 8'h00);    // jz 0x0030 (taken)
        mem[15] = 8'hFF;                  // wrong path
        put3(48, 8'h09, 8'h01, 8'h00);    // cmp B, A -> borrow
        mem[51] = 8'hFF;
        push_reads(0, 15);
        push_reads(48, 4);
        run("R10 halt p2");
        chk(regs == {8'd0, 8'd0, 8'd9, 8'd252}, "R5 R6 regs p2", regs, {8'd0, 8'd0, 8'd9, 8'd252});
        chk(zero == 1'b0, "R6 zero after cmp", {31'h0, zero}, 32'h0);
        chk(carry == 1'b1, "R6 borrow after cmp", {31'h0, carry}, 32'h1);

        // ---- Program 3: absolute jump, conditional loop (R7, R8, R5)
        hold_reset();
        clear_mem();
        put3(0,   8'h01, 8'h00, 8'd3);    // A = 3
        put3(3,   8'h04, 8'h20, 8'h01);   // jmp 0x0120
        mem[6] = 8'hFF;                   // skipped
        put3(288, 8'h01, 8'h01, 8'd0);    // B = 0 -> zero
        put3(291, 8'h06, 8'h10, 8'h00);   // jnz: not taken
        put3(294, 8'h05, 8'h40, 8'h00);   // jz 0x0040: taken
        put3(64,  8'h01, 8'h02, 8'd1);    // C = 1
        put3(67,  8'h03, 8'h00, 8'h02);   // A = A - C
        put3(70,  8'h06, 8'h40, 8'h00);   // jnz 0x0040
        mem[73] = 8'hFF;
        push_reads(0, 6);
        push_reads(288, 9);
        push_reads(64, 9);
        push_reads(64, 9);
        push_reads(64, 9);
        push_reads(73, 1);
        run("R10 halt p3");
        chk(regs == {8'd0, 8'd1, 8'd0, 8'd0}, "R7 R8 regs p3", regs, {8'd0, 8'd1, 8'd0, 8'd0});
        chk(zero == 1'b1 && carry == 1'b0, "R5 flags at loop end", {30'h0, zero, carry}, 32'h2);

        // ---- Program 4: illegal opcode (R11)
        hold_reset();
        clear_mem();
        put3(0, 8'h01, 8'h03, 8'd9);      // D = 9
        mem[3] = 8'h0A;                   // not in map
        push_reads(0, 4);
        run("R11 halt on illegal");
        chk(error == 1'b1, "R11 error", {31'h0, error}, 32'h1);
        chk(regs == {8'd9, 8'd0, 8'd0, 8'd0}, "R11 regs", regs, {8'd9, 8'd0, 8'd0, 8'd0});
        chk(mem_rd == 1'b0, "R10 no read while stopped", {31'h0, mem_rd}, 32'h0);

        finish_run();
    end

endmodule